// File: doc/BRIEF.md
# Exception and Interrupt Entry Sequencer

This block carries out the entry half of exception and interrupt handling for a RISC core. Each cycle it looks at a floating-point exception request, a non-maskable interrupt request and a bank of level-ordered maskable interrupt requests. It also takes the core's current program counter, status word, stack register (R15) and vector base. When it accepts an event, it captures the interrupted context into three shadow registers and records an event code. It raises the privilege, register-bank and event-block bits of the status word and issues a redirect to the handler address.

Exceptions and interrupts record their codes in two separate event registers, so a handler can read either one without disturbing the other. A floating-point exception is taken unconditionally. An interrupt is taken only when the status word does not block events, or when the core reports that it is in a low-power state. Only one level of entry is handled. The core is expected to present the updated status word back on the next event.

Top module: `exc_entry_seq`

## Requirements
- R1: While rst is high at a clock edge, redirect_vld, redirect_pc, sr_new, saved_pc, saved_sr, saved_r15, exc_event and int_event all become zero.
- R2: A floating-point exception sampled at an edge loads saved_pc from cur_pc, saved_sr from cur_sr and saved_r15 from cur_r15. It sets exc_event to 0x120 and redirect_pc to cur_vbr + 0x100, and leaves int_event unchanged. It is taken whatever the value of cur_sr bit 28.
- R3: On every entry, sr_new equals cur_sr with bit 30 (privilege), bit 29 (register bank) and bit 28 (event block) set to 1 and all other bits copied unchanged.
- R4: An accepted interrupt loads saved_pc, saved_sr and saved_r15 in the same way as an exception. It writes the chosen source code into int_event, leaves exc_event unchanged and sets redirect_pc to cur_vbr + 0x600.
- R5: An interrupt is accepted only when cur_sr bit 28 is 0 or low_power is 1. Otherwise no entry happens and every output register keeps its value.
- R6: nmi_req takes precedence over all maskable requests, and its code is nmi_code. Among the maskable requests, lvl_req bit i stands for level i+1 and carries code lvl_code[i*12 +: 12]. The highest level requested wins.
- R7: When a floating-point exception and an interrupt are requested in the same cycle, the exception is taken. If the interrupt request is still present after the blocked cycle, the interrupt is taken afterwards.
- R8: All register updates and redirect_pc appear together one clock edge after the request is sampled, and redirect_vld is high in exactly that cycle.
- R9: In the cycle where redirect_vld is high, requests are ignored. redirect_vld is never high in two consecutive cycles.
- R10: In a cycle with no accepted event, redirect_vld is low and all other output registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_pc | input | 32 | PC of the instruction being interrupted or faulting |
| cur_sr | input | 32 | Current status word |
| cur_r15 | input | 32 | Current R15 value |
| cur_vbr | input | 32 | Vector base address |
| fpu_req | input | 1 | Floating-point exception request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| nmi_code | input | 12 | Source code for the non-maskable interrupt |
| lvl_req | input | 14 | Maskable requests, bit i = level i+1 |
| lvl_code | input | 168 | Source codes, 12 bits per level, level 1 in the lowest field |
| low_power | input | 1 | Core is in sleep or standby |
| redirect_vld | output | 1 | One-cycle strobe: redirect and register updates are valid |
| redirect_pc | output | 32 | Handler address |
| sr_new | output | 32 | Status word to install on entry |
| saved_pc | output | 32 | Saved program counter |
| saved_sr | output | 32 | Saved status word |
| saved_r15 | output | 32 | Saved R15 |
| exc_event | output | 12 | Exception event code |
| int_event | output | 12 | Interrupt event code |

## Verification
The properties assume that every input is a defined level at each sampling edge after reset. They also assume that the core keeps requests asserted until they are served; no request is a pulse that the block must latch. The stimulus changes inputs only on the falling edge and returns every request to zero between vectors, except in the directed cases that test a held request. Those cases keep the context inputs constant, so the saved values can be predicted. Status words are chosen both with and without bit 28 set, together with both values of low_power, so that every acceptance path is exercised.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  typedef enum logic [1:0] {
    ENT_NONE = 2'd0,
    ENT_EXC  = 2'd1,
    ENT_IRQ  = 2'd2
  } ent_kind_e;

  localparam int SR_PRIV_BIT  = 30;
  localparam int SR_BANK_BIT  = 29;
  localparam int SR_BLOCK_BIT = 28;

  localparam int EXC_VEC_OFS  = 'h100;
  localparam int IRQ_VEC_OFS  = 'h600;
  localparam int FPU_EVT_CODE = 'h120;

endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NLVL   = 14,
  parameter int CODE_W = 12
) (
  input  logic                     nmi_req,
  input  logic [CODE_W-1:0]        nmi_code,
  input  logic [NLVL-1:0]          lvl_req,
  input  logic [NLVL*CODE_W-1:0]   lvl_code,
  output logic                     irq_hit,
  output logic [CODE_W-1:0]        irq_code
);

  logic [NLVL-1:0]   hit_c;
  logic [CODE_W-1:0] code_c [NLVL];

  // chain from level 1 upward: a higher level overrides everything below it
  assign hit_c[0]  = lvl_req[0];
  assign code_c[0] = lvl_req[0] ? lvl_code[0 +: CODE_W] : '0;

  for (genvar i = 1; i < NLVL; i++) begin : g_lvl
    assign hit_c[i]  = lvl_req[i] | hit_c[i-1];
    assign code_c[i] = lvl_req[i] ? lvl_code[i*CODE_W +: CODE_W] : code_c[i-1];
  end

  always_comb begin
    if (nmi_req) begin
      irq_hit  = 1'b1;
      irq_code = nmi_code;
    end else begin
      irq_hit  = hit_c[NLVL-1];
      irq_code = code_c[NLVL-1];
    end
  end

endmodule

// File: rtl/entry_arbiter.sv
module entry_arbiter
  import exc_entry_pkg::*;
(
  input  logic      fpu_req,
  input  logic      irq_hit,
  input  logic      sr_block,
  input  logic      low_power,
  input  logic      busy,
  output ent_kind_e kind
);

  logic irq_ok;

  assign irq_ok = irq_hit & (~sr_block | low_power);

  always_comb begin
    if (busy)         kind = ENT_NONE;
    else if (fpu_req) kind = ENT_EXC;
    else if (irq_ok)  kind = ENT_IRQ;
    else              kind = ENT_NONE;
  end

endmodule

// File: rtl/entry_state.sv
module entry_state
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  ent_kind_e         kind,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   cur_r15,
  input  logic [XLEN-1:0]   cur_vbr,
  input  logic [CODE_W-1:0] irq_code,
  output logic              redirect_vld,
  output logic [XLEN-1:0]   redirect_pc,
  output logic [XLEN-1:0]   sr_new,
  output logic [XLEN-1:0]   saved_pc,
  output logic [XLEN-1:0]   saved_sr,
  output logic [XLEN-1:0]   saved_r15,
  output logic [CODE_W-1:0] exc_event,
  output logic [CODE_W-1:0] int_event
);

  localparam logic [XLEN-1:0] ENTRY_SET =
      (XLEN'(1) << SR_PRIV_BIT) | (XLEN'(1) << SR_BANK_BIT) | (XLEN'(1) << SR_BLOCK_BIT);
  localparam logic [XLEN-1:0]   EXC_OFS  = XLEN'(EXC_VEC_OFS);
  localparam logic [XLEN-1:0]   IRQ_OFS  = XLEN'(IRQ_VEC_OFS);
  localparam logic [CODE_W-1:0] FPU_CODE = CODE_W'(FPU_EVT_CODE);

  logic take;
  assign take = (kind != ENT_NONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      redirect_vld <= 1'b0;
      redirect_pc  <= '0;
      sr_new       <= '0;
      saved_pc     <= '0;
      saved_sr     <= '0;
      saved_r15    <= '0;
      exc_event    <= '0;
      int_event    <= '0;
    end else begin
      redirect_vld <= take;
      if (take) begin
        saved_pc  <= cur_pc;
        saved_sr  <= cur_sr;
        saved_r15 <= cur_r15;
        sr_new    <= cur_sr | ENTRY_SET;
      end
      if (kind == ENT_EXC) begin
        exc_event   <= FPU_CODE;
        redirect_pc <= cur_vbr + EXC_OFS;
      end else if (kind == ENT_IRQ) begin
        int_event   <= irq_code;
        redirect_pc <= cur_vbr + IRQ_OFS;
      end
    end
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int NLVL   = 14,
  parameter int CODE_W = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [XLEN-1:0]        cur_pc,
  input  logic [XLEN-1:0]        cur_sr,
  input  logic [XLEN-1:0]        cur_r15,
  input  logic [XLEN-1:0]        cur_vbr,
  input  logic                   fpu_req,
  input  logic                   nmi_req,
  input  logic [CODE_W-1:0]      nmi_code,
  input  logic [NLVL-1:0]        lvl_req,
  input  logic [NLVL*CODE_W-1:0] lvl_code,
  input  logic                   low_power,
  output logic                   redirect_vld,
  output logic [XLEN-1:0]        redirect_pc,
  output logic [XLEN-1:0]        sr_new,
  output logic [XLEN-1:0]        saved_pc,
  output logic [XLEN-1:0]        saved_sr,
  output logic [XLEN-1:0]        saved_r15,
  output logic [CODE_W-1:0]      exc_event,
  output logic [CODE_W-1:0]      int_event
);

  logic              irq_hit;
  logic [CODE_W-1:0] irq_code;
  ent_kind_e         kind;

  irq_prio_pick #(.NLVL(NLVL), .CODE_W(CODE_W)) u_pick (
    .nmi_req  (nmi_req),
    .nmi_code (nmi_code),
    .lvl_req  (lvl_req),
    .lvl_code (lvl_code),
    .irq_hit  (irq_hit),
    .irq_code (irq_code)
  );

  entry_arbiter u_arb (
    .fpu_req   (fpu_req),
    .irq_hit   (irq_hit),
    .sr_block  (cur_sr[SR_BLOCK_BIT]),
    .low_power (low_power),
    .busy      (redirect_vld),
    .kind      (kind)
  );

  entry_state #(.XLEN(XLEN), .CODE_W(CODE_W)) u_state (
    .clk          (clk),
    .rst          (rst),
    .kind         (kind),
    .cur_pc       (cur_pc),
    .cur_sr       (cur_sr),
    .cur_r15      (cur_r15),
    .cur_vbr      (cur_vbr),
    .irq_code     (irq_code),
    .redirect_vld (redirect_vld),
    .redirect_pc  (redirect_pc),
    .sr_new       (sr_new),
    .saved_pc     (saved_pc),
    .saved_sr     (saved_sr),
    .saved_r15    (saved_r15),
    .exc_event    (exc_event),
    .int_event    (int_event)
  );

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk #(
  parameter int XLEN   = 32,
  parameter int NLVL   = 14,
  parameter int CODE_W = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic [XLEN-1:0]        cur_sr,
  input logic [XLEN-1:0]        cur_vbr,
  input logic                   fpu_req,
  input logic                   nmi_req,
  input logic [CODE_W-1:0]      nmi_code,
  input logic                   low_power,
  input logic                   redirect_vld,
  input logic [XLEN-1:0]        redirect_pc,
  input logic [XLEN-1:0]        sr_new,
  input logic [XLEN-1:0]        saved_pc,
  input logic [XLEN-1:0]        saved_sr,
  input logic [XLEN-1:0]        saved_r15,
  input logic [CODE_W-1:0]      exc_event,
  input logic [CODE_W-1:0]      int_event
);

  p_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    redirect_vld |=> !redirect_vld);

  p_exc_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (fpu_req && !redirect_vld) |=>
      (redirect_vld && exc_event == CODE_W'('h120) &&
       redirect_pc == $past(cur_vbr) + XLEN'('h100)));

  p_sr_bits_r3: assert property (@(posedge clk) disable iff (rst)
    redirect_vld |-> (sr_new[30:28] == 3'b111));

  p_blocked_r5: assert property (@(posedge clk) disable iff (rst)
    (!fpu_req && cur_sr[28] && !low_power) |=> !redirect_vld);

  p_nmi_entry_r4: assert property (@(posedge clk) disable iff (rst)
    (nmi_req && !fpu_req && (!cur_sr[28] || low_power) && !redirect_vld) |=>
      (redirect_vld && int_event == $past(nmi_code) &&
       redirect_pc == $past(cur_vbr) + XLEN'('h600)));

  p_exc_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (fpu_req && nmi_req && !redirect_vld) |=> $stable(int_event));

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !redirect_vld |-> ($stable(saved_pc) && $stable(saved_sr) &&
                       $stable(saved_r15) && $stable(exc_event) && $stable(int_event)));

endmodule

bind exc_entry_seq exc_entry_chk #(.XLEN(XLEN), .NLVL(NLVL), .CODE_W(CODE_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .cur_sr       (cur_sr),
  .cur_vbr      (cur_vbr),
  .fpu_req      (fpu_req),
  .nmi_req      (nmi_req),
  .nmi_code     (nmi_code),
  .low_power    (low_power),
  .redirect_vld (redirect_vld),
  .redirect_pc  (redirect_pc),
  .sr_new       (sr_new),
  .saved_pc     (saved_pc),
  .saved_sr     (saved_sr),
  .saved_r15    (saved_r15),
  .exc_event    (exc_event),
  .int_event    (int_event)
);

// File: tb/sim_exc_entry_seq.sv
module sim_exc_entry_seq;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int XLEN   = 32;
  localparam int NLVL   = 14;
  localparam int CODE_W = 12;
  localparam int NVEC   = 9;

  // {fpu, nmi, lvl[13:0], block, low_power, kind(0 none/1 exc/2 irq), code}
  localparam logic [31:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 14'h0000, 1'b0, 1'b0, 2'd1, 12'h120}, // R2 plain exception
    {1'b1, 1'b0, 14'h0000, 1'b1, 1'b0, 2'd1, 12'h120}, // R2 exception while blocked
    {1'b0, 1'b0, 14'h2001, 1'b0, 1'b0, 2'd2, 12'h3A0}, // R6 level 14 over level 1
    {1'b0, 1'b0, 14'h0011, 1'b0, 1'b0, 2'd2, 12'h280}, // R6 level 5 over level 1
    {1'b0, 1'b1, 14'h2000, 1'b0, 1'b0, 2'd2, 12'h1C0}, // R6 nmi over level 14
    {1'b0, 1'b0, 14'h0004, 1'b1, 1'b0, 2'd0, 12'h000}, // R5 blocked
    {1'b0, 1'b0, 14'h0004, 1'b1, 1'b1, 2'd2, 12'h240}, // R5 low power override
    {1'b1, 1'b1, 14'h0000, 1'b0, 1'b0, 2'd1, 12'h120}, // R7 exception wins
    {1'b0, 1'b0, 14'h0000, 1'b0, 1'b0, 2'd0, 12'h000}  // R10 idle
  };

  logic                   clk = 1'b0;
  logic                   rst;
  logic [XLEN-1:0]        cur_pc, cur_sr, cur_r15, cur_vbr;
  logic                   fpu_req, nmi_req, low_power;
  logic [CODE_W-1:0]      nmi_code;
  logic [NLVL-1:0]        lvl_req;
  logic [NLVL*CODE_W-1:0] lvl_code;
  logic                   redirect_vld;
  logic [XLEN-1:0]        redirect_pc, sr_new, saved_pc, saved_sr, saved_r15;
  logic [CODE_W-1:0]      exc_event, int_event;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [XLEN-1:0]   m_pc, m_sr_new, m_spc, m_ssr, m_sgr;
  logic [CODE_W-1:0] m_exc, m_int;

  always #2ns clk = ~clk;

  exc_entry_seq #(.XLEN(XLEN), .NLVL(NLVL), .CODE_W(CODE_W)) u0 (
    .clk(clk), .rst(rst), .cur_pc(cur_pc), .cur_sr(cur_sr), .cur_r15(cur_r15),
    .cur_vbr(cur_vbr), .fpu_req(fpu_req), .nmi_req(nmi_req), .nmi_code(nmi_code),
    .lvl_req(lvl_req), .lvl_code(lvl_code), .low_power(low_power),
    .redirect_vld(redirect_vld), .redirect_pc(redirect_pc), .sr_new(sr_new),
    .saved_pc(saved_pc), .saved_sr(saved_sr), .saved_r15(saved_r15),
    .exc_event(exc_event), .int_event(int_event)
  );

  task automatic check(input string req, input string what,
                       input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic check_regs(input string req, input logic exp_vld);
    check(req, "redirect_vld", XLEN'(redirect_vld), XLEN'(exp_vld));
    check(req, "redirect_pc", redirect_pc, m_pc);
    check(req, "sr_new", sr_new, m_sr_new);
    check(req, "saved_pc", saved_pc, m_spc);
    check(req, "saved_sr", saved_sr, m_ssr);
    check(req, "saved_r15", saved_r15, m_sgr);
    check(req, "exc_event", XLEN'(exc_event), XLEN'(m_exc));
    check(req, "int_event", XLEN'(int_event), XLEN'(m_int));
  endtask

  // model of one entry from the context now on the inputs
  task automatic model_take(input logic [1:0] kind, input logic [CODE_W-1:0] code);
    m_spc    = cur_pc;
    m_ssr    = cur_sr;
    m_sgr    = cur_r15;
    m_sr_new = cur_sr | 32'h7000_0000;
    if (kind == 2'd1) begin
      m_exc = 12'h120;
      m_pc  = cur_vbr + 32'h100;
    end else begin
      m_int = code;
      m_pc  = cur_vbr + 32'h600;
    end
  endtask

  task automatic model_reset();
    m_pc = '0; m_sr_new = '0; m_spc = '0; m_ssr = '0; m_sgr = '0; m_exc = '0; m_int = '0;
  endtask

  task automatic clear_reqs();
    fpu_req = 1'b0; nmi_req = 1'b0; lvl_req = '0; low_power = 1'b0;
  endtask

  initial begin
    #800us;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    clear_reqs();
    cur_pc = '0; cur_sr = '0; cur_r15 = '0; cur_vbr = 32'h0C00_0000;
    nmi_code = 12'h1C0;
    for (int i = 0; i < NLVL; i++) lvl_code[i*CODE_W +: CODE_W] = 12'h200 + CODE_W'(i * 32);
    model_reset();
    repeat (3) @(posedge clk);
    #1ns;
    check_regs("R1", 1'b0); // reset state
    @(negedge clk);
    rst = 1'b0;

    // table walk: R2 R3 R4 R5 R6 R7 R8 R10
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      cur_pc    = 32'h0000_1000 + 32'(i * 4);
      cur_r15   = 32'h8000_0000 + 32'(i);
      cur_sr    = 32'h0000_00F0 | (32'(VEC[i][15]) << 28);
      fpu_req   = VEC[i][31];
      nmi_req   = VEC[i][30];
      lvl_req   = VEC[i][29:16];
      low_power = VEC[i][14];
      @(posedge clk);
      #1ns;
      if (VEC[i][13:12] != 2'd0) model_take(VEC[i][13:12], VEC[i][11:0]);
      check_regs(VEC[i][13:12] == 2'd0 ? "R5/R10" : "R8", VEC[i][13:12] != 2'd0);
      @(negedge clk);
      clear_reqs();
      @(posedge clk);
    end

    // R7: interrupt stays pending behind the exception and is taken later
    @(negedge clk);
    cur_pc = 32'h0000_2000; cur_sr = 32'h0000_0003; cur_r15 = 32'h1234_5678;
    fpu_req = 1'b1; nmi_req = 1'b1;
    @(posedge clk); #1ns;
    model_take(2'd1, 12'h0);
    check_regs("R7", 1'b1);
    @(negedge clk);
    fpu_req = 1'b0;
    @(posedge clk); #1ns;
    check_regs("R9", 1'b0); // held request ignored in strobe cycle
    @(posedge clk); #1ns;
    model_take(2'd2, 12'h1C0);
    check_regs("R7", 1'b1);
    @(negedge clk);
    clear_reqs();
    @(posedge clk);

    // R9: a held maskable request re-enters only every other cycle
    @(negedge clk);
    cur_pc = 32'h0000_3000;
    lvl_req = 14'h0020;
    @(posedge clk); #1ns;
    model_take(2'd2, 12'h2A0);
    check_regs("R9", 1'b1);
    @(posedge clk); #1ns;
    check_regs("R9", 1'b0);
    @(posedge clk); #1ns;
    check_regs("R9", 1'b1);
    @(negedge clk);
    clear_reqs();

    // R1: reset in the middle of operation
    rst = 1'b1;
    @(posedge clk); #1ns;
    model_reset();
    check_regs("R1", 1'b0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule